// File: doc/BRIEF.md
# DMA Request Router and Interrupt Summary

This block sits between a set of peripheral request lines and a bank of DMA channels. Each of the 40 request sources has its own routing register. The register holds an enable bit and a 4-bit channel number. While the enable bit is set, the source's request line is steered to the selected channel's request output. Several enabled sources may select one channel. Their requests then combine by OR onto that channel. Routing is purely combinational, so a request reaches its channel in the same cycle it arrives.

The block also gathers the 16 per-channel interrupt lines into one sticky summary register, and drives a single combined interrupt from it. Software reads the summary, services the channels, and writes the value it read back to the summary address. Each bit written as one clears that bit. A channel that still holds its interrupt line high keeps or regains its summary bit.

Register access uses a plain write strobe, an address and write data. Read data is combinational on the address.
- Addresses 0 to 39 are the routing registers.
- Address 40 is the summary register.
- Every higher address reads zero.

Top module: `dma_req_router`

## Requirements
- R1: After reset, every routing register and the summary register read zero, no channel request output is asserted whatever the request inputs are, and the combined interrupt is low.
- R2: A routing register at address s (0..39) stores write-data bit 7 as its enable and bits 3:0 as its channel number; it reads back with those bits in the same positions and all other bits zero.
- R3: While source s is enabled and its channel field is c, a high on request input s drives request output c high in the same cycle.
- R4: A source whose enable bit is 0 drives no request output; writing a value with bit 7 clear to a routing register disconnects that source.
- R5: Each request output is the OR of the request inputs of all enabled sources whose channel field selects it.
- R6: A channel interrupt input that is high at a clock edge sets bit c of the summary register (address 40) after that edge; the bit stays set after the input falls.
- R7: A write to address 40 clears exactly the summary bits written as one; bits written as zero are unchanged.
- R8: A summary bit whose channel interrupt input is high in the cycle of the clearing write remains set.
- R9: The combined interrupt output is high exactly when at least one summary bit is set.
- R10: Addresses 41 and above read zero, and writes to them change no routing register and no summary bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| req_i | input | 40 | Peripheral request inputs |
| req_o | output | 16 | Channel request outputs |
| chan_irq_i | input | 16 | Per-channel interrupt inputs |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker watches several properties on every cycle:
- The routing table never moves without a write to a routing address.
- No request output is asserted while all inputs are low.
- A summary bit can fall only under a clearing write that carries its bit.
- An asserted channel interrupt always appears in the summary one cycle later.
- The combined interrupt agrees with the summary read value.

Only the bench's scenarios can show that the routing is exact. They sweep every source across distinct channels, program shared channels with multi-source patterns, disconnect sources, and walk every channel through set and clear. Decoding of the unused addresses is also shown only by these scenarios.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  localparam int EN_BIT   = 7;
  localparam int CHF_W    = 4;
  localparam int REG_W    = 32;

  typedef struct packed {
    logic             en;
    logic [CHF_W-1:0] chan;
  } route_t;
endpackage

// File: rtl/dma_rr_route_regs.sv
module dma_rr_route_regs
  import dma_rr_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int ADDR_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output route_t [N_SRC-1:0]       route_o
);
  route_t [N_SRC-1:0] route_q;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        route_q[s] <= '0;
      end else if (we_i && addr_i == ADDR_W'(s)) begin
        route_q[s].en   <= wdata_i[EN_BIT];
        route_q[s].chan <= wdata_i[CHF_W-1:0];
      end
    end
  end

  assign route_o = route_q;
endmodule

// File: rtl/dma_rr_xbar.sv
module dma_rr_xbar
  import dma_rr_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int N_CH  = 16
) (
  input  logic [N_SRC-1:0]   req_i,
  input  route_t [N_SRC-1:0] route_i,
  output logic [N_CH-1:0]    req_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
        acc = acc | (req_i[s] & route_i[s].en & (route_i[s].chan == CHF_W'(c)));
      end
      req_o[c] = acc;
    end
  end
endmodule

// File: rtl/dma_rr_irq_sum.sv
module dma_rr_irq_sum #(
  parameter int N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] chan_irq_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] sum_o,
  output logic            irq_o
);
  logic [N_CH-1:0] sum_q;

  // live interrupt wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= chan_irq_i | (sum_q & ~clr_i);
  end

  assign sum_o = sum_q;
  assign irq_o = |sum_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rr_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int N_CH   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [N_SRC-1:0]  req_i,
  output logic [N_CH-1:0]   req_o,
  input  logic [N_CH-1:0]   chan_irq_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(N_SRC);

  route_t [N_SRC-1:0] route;
  logic   [N_CH-1:0]  sum;
  logic   [N_CH-1:0]  clr;

  assign clr = (reg_we_i && reg_addr_i == SUM_ADDR) ? reg_wdata_i[N_CH-1:0] : '0;

  dma_rr_route_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .route_o (route)
  );

  dma_rr_xbar #(.N_SRC(N_SRC), .N_CH(N_CH)) u_xbar (
    .req_i   (req_i),
    .route_i (route),
    .req_o   (req_o)
  );

  dma_rr_irq_sum #(.N_CH(N_CH)) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_irq_i (chan_irq_i),
    .clr_i      (clr),
    .sum_o      (sum),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (reg_addr_i == ADDR_W'(s)) begin
        reg_rdata_o[EN_BIT]      = route[s].en;
        reg_rdata_o[CHF_W-1:0]   = route[s].chan;
      end
    end
    if (reg_addr_i == SUM_ADDR) reg_rdata_o[N_CH-1:0] = sum;
  end
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk #(
  parameter int N_SRC  = 40,
  parameter int N_CH   = 16,
  parameter int ADDR_W = 6,
  parameter int RT_W   = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   reg_we_i,
  input logic [ADDR_W-1:0]      reg_addr_i,
  input logic [31:0]            reg_wdata_i,
  input logic [31:0]            reg_rdata_o,
  input logic [N_SRC-1:0]       req_i,
  input logic [N_CH-1:0]        req_o,
  input logic [N_CH-1:0]        chan_irq_i,
  input logic                   irq_o,
  input logic [N_CH-1:0]        sum,
  input logic [N_SRC*RT_W-1:0]  route_bits
);
  logic [N_CH-1:0] wr_mask;
  assign wr_mask = (reg_we_i && reg_addr_i == ADDR_W'(N_SRC)) ? reg_wdata_i[N_CH-1:0] : '0;

  // R3: no request out while every request input is low
  a_r3_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (req_o == '0));

  // R6 / R8: an interrupt present at an edge is in the summary afterwards
  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(chan_irq_i) & ~sum) == '0));

  // R7: a summary bit falls only under a clearing write carrying it
  a_r7_only_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sum) & ~sum & ~$past(wr_mask)) == '0));

  // R9: combined interrupt agrees with the summary read value
  a_r9_irq_matches_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(N_SRC)) |-> ((reg_rdata_o != '0) == irq_o));

  // R10: routing table changes only on a write to a routing address
  a_r10_route_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i < ADDR_W'(N_SRC)) |=> $stable(route_bits));
endmodule

bind dma_req_router dma_req_router_chk #(
  .N_SRC(N_SRC), .N_CH(N_CH), .ADDR_W(ADDR_W), .RT_W($bits(dma_rr_pkg::route_t))
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .req_i       (req_i),
  .req_o       (req_o),
  .chan_irq_i  (chan_irq_i),
  .irq_o       (irq_o),
  .sum         (sum),
  .route_bits  (route)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb;
  localparam int NS = 40;
  localparam int NC = 16;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [NS-1:0] req_i = '0;
  logic [NC-1:0] req_o;
  logic [NC-1:0] chan_irq_i = '0;
  logic          irq_o;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  m_en [NS];
  int  m_ch [NS];

  always #2 clk_i = ~clk_i;

  dma_req_router u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a < NS) begin m_en[a] = d[7]; m_ch[a] = int'(d[3:0]); end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr_i = AW'(a);
    #1;
    d = reg_rdata_o;
  endtask

  function automatic logic [NC-1:0] model_req(input logic [NS-1:0] p);
    logic [NC-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      if (p[s] && m_en[s]) r[m_ch[s]] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int s = 0; s < NS; s++) begin m_en[s] = 0; m_ch[s] = 0; end
    req_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R1 req_o in reset", 64'(req_o), 0);
    chk("R1 irq_o in reset", 64'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 req_o after reset", 64'(req_o), 0);
    for (int a = 0; a <= NS; a++) begin
      rd(a, d);
      chk("R1 register reset value", 64'(d), 0);
    end
    req_i = '0;

    // R2 field layout
    wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R2 readback ones", 64'(d), 64'h8F);
    wr(5, 32'h0000_0083); rd(5, d); chk("R2 readback 83", 64'(d), 64'h83);
    wr(5, 32'h0000_0000);

    // R3 / R4 sweep every source
    for (int s = 0; s < NS; s++) begin
      int c = (s * 7 + 3) % NC;
      wr(s, 32'h80 | 32'(c));
      req_i = NS'(1) << s; #1;
      chk("R3 single route", 64'(req_o), 64'(NC'(1) << c));
      req_i = '0;
      wr(s, 32'(c));
      req_i = NS'(1) << s; #1;
      chk("R4 disabled source", 64'(req_o), 0);
      req_i = '0;
    end

    // R5 shared channels
    for (int s = 0; s < NS; s++) wr(s, ((s % 3) != 0 ? 32'h80 : 32'h0) | 32'(s % NC));
    for (int i = 0; i < NS; i++) begin
      logic [NS-1:0] p;
      p = (NS'(1) << i) | (NS'(1) << ((i * 13 + 7) % NS)) | (NS'(1) << ((i * 29 + 1) % NS));
      req_i = p; #1;
      chk("R5 OR of sources", 64'(req_o), 64'(model_req(p)));
    end
    req_i = '1; #1;
    chk("R5 all requests", 64'(req_o), 64'(model_req('1)));
    req_i = '0;

    // R10 unused addresses
    for (int a = NS + 1; a < (1 << AW); a++) wr(a, 32'hFFFF_FFFF);
    for (int s = 0; s < NS; s++) begin
      rd(s, d);
      chk("R10 route unchanged", 64'(d), 64'((m_en[s] ? 32'h80 : 32'h0) | 32'(m_ch[s])));
    end
    rd(50, d); chk("R10 unused reads zero", 64'(d), 0);
    rd(NS, d); chk("R10 summary untouched", 64'(d), 0);

    // R6..R9 interrupt summary
    @(negedge clk_i);
    chan_irq_i = 16'h0005; #1;
    chk("R6 not yet captured", 64'(irq_o), 0);
    @(negedge clk_i);
    rd(NS, d); chk("R6 capture", 64'(d), 64'h5);
    chk("R9 irq high", 64'(irq_o), 1);
    chan_irq_i = '0;
    @(negedge clk_i);
    rd(NS, d); chk("R6 sticky", 64'(d), 64'h5);
    wr(NS, 32'h1); rd(NS, d); chk("R7 clear one bit", 64'(d), 64'h4);
    wr(NS, 32'h0); rd(NS, d); chk("R7 zero write keeps", 64'(d), 64'h4);
    chan_irq_i = 16'h0004;
    wr(NS, 32'h4); rd(NS, d); chk("R8 live irq survives clear", 64'(d), 64'h4);
    chan_irq_i = '0;
    wr(NS, 32'h4); rd(NS, d); chk("R7 cleared", 64'(d), 0);
    chk("R9 irq low", 64'(irq_o), 0);
    for (int c = 0; c < NC; c++) begin
      @(negedge clk_i);
      chan_irq_i = NC'(1) << c;
      @(negedge clk_i);
      chan_irq_i = '0;
      rd(NS, d); chk("R6 channel sweep", 64'(d), 64'(NC'(1) << c));
      chk("R9 sweep high", 64'(irq_o), 1);
      wr(NS, 32'(NC'(1) << c));
      rd(NS, d); chk("R7 sweep clear", 64'(d), 0);
      chk("R9 sweep low", 64'(irq_o), 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule